// File: doc/BRIEF.md
# Segmented Sector Buffer Write Pointer

This block turns a stream of incoming disc-sector bytes into write addresses for a buffer RAM. The RAM is divided into fixed segments of 2560 bytes, and each sector lands at the start of a segment. The block keeps a current segment number and a count of blocks left in the current run. A second pair of registers holds the segment and count to use for the following run. Each sector sync moves the pointers forward. When the run is used up, the next pair is copied into the current pair and an interrupt flag is raised.

Every byte that is counted gets the address segment × 2560 + offset. The offset restarts at each sync and stops at a mode-dependent sector length. A write-disable control lets the pointers run ahead without storing any data. One mode skips bytes marked by a per-byte flag. Firmware loads the registers through a simple select/data write strobe. It reads the current segment, the block count and the previous segment back on dedicated outputs.

Top module: `segbuf_wrptr`

## Requirements
- R1: After reset, wr_en, irq, cur_seg, cur_cnt and prev_seg are all 0, and the offset is 0.
- R2: A counted byte strobe produces, on the next clock, wr_en=1, wr_addr = cur_seg × 2560 + offset and wr_data equal to the byte. The offset then advances by one.
- R3: At a sync that does not reload, cur_seg increments by one when inc_en=1 and holds its value when inc_en=0.
- R4: At a sync that does not reload, cur_cnt decrements by one, whatever inc_en is.
- R5: While wr_dis=1, counted bytes raise no wr_en, but the offset still advances. Pointers and counter still step at syncs.
- R6: At every sync, prev_seg takes the value cur_seg had just before that sync.
- R7: A sync that finds cur_cnt ≤ 1 reloads cur_seg and cur_cnt from the next-segment and next-count registers. If the next registers are left unchanged, the run repeats over the same segments.
- R8: A reload with irq_en=1 sets irq. irq stays set until an irq_ack pulse arrives. A reload in the same cycle as irq_ack wins, so irq stays set. With irq_en=0 a reload leaves irq unchanged.
- R9: mod_sel sets the sector length: 00 and 01 give 2352 bytes, 10 and 11 give 2064 bytes. Once the offset reaches the length, further bytes before the next sync are neither written nor counted.
- R10: With mod_sel=11, bytes with byte_flag=1 are neither written nor counted. In every other mode the flag has no effect.
- R11: Each sync resets the offset to 0. A byte strobe in the same cycle as a sync is dropped.
- R12: A register write (reg_we=1) loads the register chosen by reg_sel: 00 current segment, 01 current count, 10 next segment, 11 next count. A register write in the same cycle as a sync is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Incoming sector byte strobe |
| byte_data | input | 8 | Incoming sector byte |
| byte_flag | input | 1 | Per-byte error mark |
| sec_sync | input | 1 | Sector sync pulse |
| mod_sel | input | 2 | Sector length / flag-skip mode |
| inc_en | input | 1 | Advance segment at each sync |
| wr_dis | input | 1 | Suppress RAM writes |
| irq_en | input | 1 | Allow reload interrupt |
| irq_ack | input | 1 | Clear interrupt flag |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | 28 | RAM byte address |
| wr_data | output | 8 | RAM write byte |
| cur_seg | output | 16 | Current segment |
| cur_cnt | output | 16 | Blocks left in run |
| prev_seg | output | 16 | Segment before last sync |
| irq | output | 1 | Reload interrupt flag |

## Verification
If the offset goes wrong, the next write address shows it one clock after the byte strobe. So a missed sync reset, a counted flagged byte or a missing saturation shows up on the very next write. An error in the segment or counter state shows on cur_seg or cur_cnt at the clock after the sync. An error in the reload decision may stay hidden until the end of the run, when the segment jumps to the wrong place and irq comes at the wrong sync. For this reason the bench drives runs through to reload and on into a second loop.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
  localparam int unsigned SEG_BYTES_DEF = 2560;
  localparam int unsigned LEN_FULL_DEF  = 2352;
  localparam int unsigned LEN_SHORT_DEF = 2064;

  typedef enum logic [1:0] {
    SEL_CUR_SEG = 2'b00,
    SEL_CUR_CNT = 2'b01,
    SEL_NXT_SEG = 2'b10,
    SEL_NXT_CNT = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    MOD_FULL      = 2'b00,
    MOD_FULL_ALT  = 2'b01,
    MOD_SHORT     = 2'b10,
    MOD_SHORT_SKP = 2'b11
  } mod_sel_e;
endpackage

// File: rtl/segbuf_ptr_ctrl.sv
module segbuf_ptr_ctrl #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_sync,
  input  logic             inc_en,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [SEG_W-1:0] cur_seg,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [SEG_W-1:0] prev_seg,
  output logic             irq
);
  import segbuf_pkg::*;

  logic [SEG_W-1:0] nxt_seg;
  logic [CNT_W-1:0] nxt_cnt;
  logic             reload;

  // run exhausted: counter at 1 (or already empty) when the sync arrives
  assign reload = sec_sync && (cur_cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_seg  <= '0;
      cur_cnt  <= '0;
      nxt_seg  <= '0;
      nxt_cnt  <= '0;
      prev_seg <= '0;
    end else if (sec_sync) begin
      prev_seg <= cur_seg;
      if (reload) begin
        cur_seg <= nxt_seg;
        cur_cnt <= nxt_cnt;
      end else begin
        cur_cnt <= cur_cnt - CNT_W'(1);
        if (inc_en) cur_seg <= cur_seg + SEG_W'(1);
      end
    end else if (reg_we) begin
      case (reg_sel_e'(reg_sel))
        SEL_CUR_SEG: cur_seg <= reg_wdata[SEG_W-1:0];
        SEL_CUR_CNT: cur_cnt <= reg_wdata[CNT_W-1:0];
        SEL_NXT_SEG: nxt_seg <= reg_wdata[SEG_W-1:0];
        default:     nxt_cnt <= reg_wdata[CNT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  irq <= 1'b0;
    else if (reload && irq_en) irq <= 1'b1;
    else if (irq_ack)          irq <= 1'b0;
  end
endmodule

// File: rtl/segbuf_off_ctr.sv
module segbuf_off_ctr #(
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned LEN_FULL  = 2352,
  parameter int unsigned LEN_SHORT = 2064
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_sync,
  input  logic             byte_vld,
  input  logic             byte_flag,
  input  logic [1:0]       mod_sel,
  output logic             take,
  output logic [OFF_W-1:0] off
);
  import segbuf_pkg::*;

  logic [OFF_W-1:0] limit;
  logic             skip_flag;

  always_comb begin
    case (mod_sel_e'(mod_sel))
      MOD_SHORT, MOD_SHORT_SKP: limit = OFF_W'(LEN_SHORT);
      default:                  limit = OFF_W'(LEN_FULL);
    endcase
  end

  assign skip_flag = (mod_sel_e'(mod_sel) == MOD_SHORT_SKP) && byte_flag;
  assign take      = byte_vld && !sec_sync && !skip_flag && (off < limit);

  always_ff @(posedge clk) begin
    if (rst || sec_sync) off <= '0;
    else if (take)       off <= off + OFF_W'(1);
  end
endmodule

// File: rtl/segbuf_addr_gen.sv
module segbuf_addr_gen #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned ADDR_W    = 28,
  parameter int unsigned SEG_BYTES = 2560
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              wr_dis,
  input  logic [SEG_W-1:0]  cur_seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        byte_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic [ADDR_W-1:0] base;

  assign base = ADDR_W'(cur_seg) * ADDR_W'(SEG_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= take && !wr_dis;
      if (take) begin
        wr_addr <= base + ADDR_W'(off);
        wr_data <= byte_data;
      end
    end
  end
endmodule

// File: rtl/segbuf_wrptr.sv
module segbuf_wrptr #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SEG_BYTES = segbuf_pkg::SEG_BYTES_DEF,
  parameter int unsigned LEN_FULL  = segbuf_pkg::LEN_FULL_DEF,
  parameter int unsigned LEN_SHORT = segbuf_pkg::LEN_SHORT_DEF,
  localparam int unsigned OFF_W    = $clog2(SEG_BYTES),
  localparam int unsigned ADDR_W   = SEG_W + OFF_W,
  localparam int unsigned REG_W    = (SEG_W > CNT_W) ? SEG_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              byte_flag,
  input  logic              sec_sync,
  input  logic [1:0]        mod_sel,
  input  logic              inc_en,
  input  logic              wr_dis,
  input  logic              irq_en,
  input  logic              irq_ack,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [SEG_W-1:0]  cur_seg,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [SEG_W-1:0]  prev_seg,
  output logic              irq
);
  logic             take;
  logic [OFF_W-1:0] off;

  segbuf_ptr_ctrl #(.SEG_W(SEG_W), .CNT_W(CNT_W), .REG_W(REG_W)) ptr_i (
    .clk(clk), .rst(rst), .sec_sync(sec_sync), .inc_en(inc_en),
    .irq_en(irq_en), .irq_ack(irq_ack), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cur_seg(cur_seg), .cur_cnt(cur_cnt),
    .prev_seg(prev_seg), .irq(irq)
  );

  segbuf_off_ctr #(.OFF_W(OFF_W), .LEN_FULL(LEN_FULL), .LEN_SHORT(LEN_SHORT)) off_i (
    .clk(clk), .rst(rst), .sec_sync(sec_sync), .byte_vld(byte_vld),
    .byte_flag(byte_flag), .mod_sel(mod_sel), .take(take), .off(off)
  );

  segbuf_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) adr_i (
    .clk(clk), .rst(rst), .take(take), .wr_dis(wr_dis), .cur_seg(cur_seg),
    .off(off), .byte_data(byte_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );
endmodule

// File: rtl/segbuf_wrptr_chk.sv
module segbuf_wrptr_chk #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_sync,
  input logic             inc_en,
  input logic             wr_dis,
  input logic             irq_en,
  input logic             irq_ack,
  input logic             wr_en,
  input logic [SEG_W-1:0] cur_seg,
  input logic [CNT_W-1:0] cur_cnt,
  input logic [SEG_W-1:0] prev_seg,
  input logic             irq
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && !wr_en && cur_seg == '0 && cur_cnt == '0 && prev_seg == '0));

  a_r3_seg_hold: assert property (@(posedge clk) disable iff (rst)
    (sec_sync && cur_cnt > CNT_W'(1) && !inc_en) |=> $stable(cur_seg));

  a_r3_seg_step: assert property (@(posedge clk) disable iff (rst)
    (sec_sync && cur_cnt > CNT_W'(1) && inc_en) |=> (cur_seg == $past(cur_seg) + SEG_W'(1)));

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (sec_sync && cur_cnt > CNT_W'(1)) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  a_r5_no_store: assert property (@(posedge clk) disable iff (rst)
    wr_dis |=> !wr_en);

  a_r6_prev_copy: assert property (@(posedge clk) disable iff (rst)
    sec_sync |=> (prev_seg == $past(cur_seg)));

  a_r8_irq_set: assert property (@(posedge clk) disable iff (rst)
    (sec_sync && cur_cnt <= CNT_W'(1) && irq_en) |=> irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  a_r11_sync_drop: assert property (@(posedge clk) disable iff (rst)
    sec_sync |=> !wr_en);
endmodule

bind segbuf_wrptr segbuf_wrptr_chk #(.SEG_W(SEG_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .sec_sync(sec_sync), .inc_en(inc_en), .wr_dis(wr_dis),
  .irq_en(irq_en), .irq_ack(irq_ack), .wr_en(wr_en), .cur_seg(cur_seg),
  .cur_cnt(cur_cnt), .prev_seg(prev_seg), .irq(irq)
);

// File: tb/segbuf_wrptr_tb.sv
module segbuf_wrptr_tb_top;
  localparam int AW = 28;
  typedef struct packed { logic [AW-1:0] addr; logic [7:0] data; } wr_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_vld = 0, byte_flag = 0, sec_sync = 0;
  logic [7:0] byte_data = 0;
  logic [1:0] mod_sel = 0;
  logic inc_en = 0, wr_dis = 0, irq_en = 0, irq_ack = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic wr_en, irq;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [15:0] cur_seg, cur_cnt, prev_seg;

  always #5 clk = ~clk;

  segbuf_wrptr dut_i (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_flag(byte_flag), .sec_sync(sec_sync), .mod_sel(mod_sel),
    .inc_en(inc_en), .wr_dis(wr_dis), .irq_en(irq_en), .irq_ack(irq_ack),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cur_seg(cur_seg),
    .cur_cnt(cur_cnt), .prev_seg(prev_seg), .irq(irq)
  );

  int n_chk = 0, n_err = 0, n_wr = 0;
  bit done = 0;
  wr_item_t exp_q[$];

  // bench-side expectation state
  int m_seg = 0, m_cnt = 0, m_prev = 0, m_nseg = 0, m_ncnt = 0, m_off = 0;
  bit m_irq = 0;
  logic [7:0] dval = 8'h11;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lim();
    return (mod_sel[1]) ? 2064 : 2352;
  endfunction

  // one byte strobe, called at a negedge
  task automatic put_byte(input bit flag);
    bit counted;
    counted = !(mod_sel == 2'b11 && flag) && (m_off < lim());
    if (counted) begin
      if (!wr_dis) exp_q.push_back('{addr: AW'(m_seg * 2560 + m_off), data: dval});
      m_off++;
    end
    byte_vld = 1; byte_flag = flag; byte_data = dval;
    @(negedge clk);
    byte_vld = 0; byte_flag = 0;
    dval = dval + 8'd7;
  endtask

  task automatic reg_wr(input logic [1:0] sel, input int val);
    case (sel)
      2'b00: m_seg = val;
      2'b01: m_cnt = val;
      2'b10: m_nseg = val;
      default: m_ncnt = val;
    endcase
    reg_we = 1; reg_sel = sel; reg_wdata = 16'(val);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic do_ack();
    m_irq = 0;
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk("R8 irq cleared by ack", irq, 0);
  endtask

  task automatic sync_pulse(input bit ack, input bit with_byte, input bit with_reg);
    bit rl;
    rl = (m_cnt <= 1);
    m_prev = m_seg;
    if (rl) begin
      m_seg = m_nseg; m_cnt = m_ncnt;
      if (irq_en) m_irq = 1;
      else if (ack) m_irq = 0;
    end else begin
      m_cnt = m_cnt - 1;
      if (inc_en) m_seg = (m_seg + 1) & 16'hFFFF;
      if (ack) m_irq = 0;
    end
    m_off = 0;
    sec_sync = 1; irq_ack = ack; byte_vld = with_byte; byte_data = dval;
    reg_we = with_reg; reg_sel = 2'b00; reg_wdata = 16'd77;
    @(negedge clk);
    sec_sync = 0; irq_ack = 0; byte_vld = 0; reg_we = 0;
    chk("R3 cur_seg after sync", cur_seg, m_seg);
    chk("R4 cur_cnt after sync", cur_cnt, m_cnt);
    chk("R6 prev_seg after sync", prev_seg, m_prev);
    chk("R8 irq after sync", irq, m_irq);
    if (rl) chk("R7 reload segment", cur_seg, m_nseg);
    if (with_reg) chk("R12 reg write lost to sync", cur_seg, m_seg);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      n_wr++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R2 unexpected write actual=%0d expected=none", wr_addr);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        if (wr_addr != e.addr || wr_data != e.data) begin
          n_err++;
          $display("FAIL R2 write actual=%0d/%0h expected=%0d/%0h", wr_addr, wr_data, e.addr, e.data);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cur_seg", cur_seg, 0);
    chk("R1 cur_cnt", cur_cnt, 0);
    chk("R1 prev_seg", prev_seg, 0);

    reg_wr(2'b10, 5);
    reg_wr(2'b11, 3);
    irq_en = 1; inc_en = 1; mod_sel = 2'b00;
    sync_pulse(0, 0, 0);              // R7 reload from empty counter
    chk("R8 irq raised", irq, 1);
    do_ack();
    for (int i = 0; i < 4; i++) put_byte(0);   // R2 addresses 12800..12803
    sync_pulse(0, 0, 0);              // R3 step, R4 decrement
    for (int i = 0; i < 2; i++) put_byte(0);
    inc_en = 0;
    sync_pulse(0, 0, 0);              // R3 hold, R4 decrement
    wr_dis = 1;
    for (int i = 0; i < 3; i++) put_byte(0);   // R5 no writes, offset moves
    wr_dis = 0;
    put_byte(0);                      // R5 lands at offset 3
    sync_pulse(1, 0, 0);              // R7 loop reload, R8 set beats ack
    chk("R8 set wins over ack", irq, 1);
    do_ack();
    irq_en = 0;
    reg_wr(2'b01, 1);
    @(negedge clk);
    chk("R12 current count write", cur_cnt, 1);
    sync_pulse(0, 0, 0);              // R8 no irq when disabled
    chk("R8 irq stays low", irq, 0);

    mod_sel = 2'b11;                  // R10 skip flagged
    put_byte(0); put_byte(1); put_byte(0); put_byte(1); put_byte(0);
    mod_sel = 2'b00;
    put_byte(1);                      // R10 flag ignored
    repeat (2) @(negedge clk);
    chk("R10 queue drained", exp_q.size(), 0);

    sync_pulse(0, 0, 0);
    mod_sel = 2'b10;
    w0 = n_wr;
    for (int i = 0; i < 2066; i++) put_byte(0);
    repeat (2) @(negedge clk);
    chk("R9 short sector writes", n_wr - w0, 2064);

    sync_pulse(0, 0, 0);
    mod_sel = 2'b01;
    w0 = n_wr;
    for (int i = 0; i < 2354; i++) put_byte(0);
    repeat (2) @(negedge clk);
    chk("R9 full sector writes", n_wr - w0, 2352);

    mod_sel = 2'b00;
    sync_pulse(0, 1, 1);              // R11 byte dropped, R12 write discarded
    put_byte(0);                      // R11 offset restarts at 0
    repeat (3) @(negedge clk);
    chk("R11 all expected writes seen", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule